// File: doc/BRIEF.md
# Terminal Mode and Command Register Unit

This unit keeps the operating mode of a serial bus terminal interface, Remote Terminal or Bus Controller, and holds the terminal-side message registers that the host reads. Command words that the serial decoder recognises are loaded into a two-stage buffer. A command moves to the host-visible stage only when the message it belongs to has been judged valid. The host can therefore read a command during the whole of the following message without the next command overwriting it.

The unit also keeps the data word of a synchronize-with-data command and a host-written vector word. Four sticky interrupt flags report receive messages, transmit messages, mode commands and command overrun. The flags are combined into one interrupt line. A validated dynamic bus control mode command moves the unit from Remote Terminal to Bus Controller mode, but only when the host has enabled acceptance. A host command strobe returns the unit to Remote Terminal mode.

Top module: `tcu_top`

## Requirements
- R1: After reset the unit is in Remote Terminal mode (mode_bc = 0), irq_o is 0, and every host read address (0 command, 1 sync, 2 vector, 3 flags, 4 control) returns 0.
- R2: In Bus Controller mode a host_go_rt pulse sets mode_bc to 0 on the next clock. In Remote Terminal mode a host_go_rt pulse has no effect.
- R3: In Remote Terminal mode, validating a pending command whose subaddress field (bits 9:5) is 0 or 31 and whose mode code field (bits 4:0) is 00000 sets mode_bc to 1 on the next clock. This happens only when control bit 0 (address 4) is 1; otherwise the mode is unchanged. Reading address 4 returns {mode_bc, enable} in bits 1:0.
- R4: dec_cmd_stb loads the first stage without changing the value read at address 0. msg_ok_stb moves the pending first-stage command to address 0.
- R5: A transfer into the second stage while the previous second-stage command has not been read sets overrun flag bit 3. Any host_rd at address 0 counts as a read. The new command replaces the old one. With a read in between, no overrun is flagged.
- R6: dec_sync_stb stores dec_word in the sync register, which reads back at address 1.
- R7: A host write to address 2 stores the vector word, which reads back at address 2.
- R8: Each transfer sets one flag. A mode command (subaddress 0 or 31) sets bit 2. Otherwise bit 10 of the command selects the flag: bit 1 when bit 10 is 1 (transmit), bit 0 when bit 10 is 0 (receive).
- R9: Flags read at address 3 stay set until a host write of 1 to that bit at address 3. Writing 0 to a bit leaves it unchanged. irq_o is 1 exactly when any flag is set.
- R10: In Bus Controller mode, dec_cmd_stb, dec_sync_stb and msg_ok_stb have no effect on the registers or flags.
- R11: msg_ok_stb with no pending first-stage command changes neither address 0 nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_cmd_stb | input | 1 | Decoder found a command word on dec_word |
| dec_sync_stb | input | 1 | Decoder found the synchronize data word on dec_word |
| dec_word | input | WORD_W | Decoded word |
| msg_ok_stb | input | 1 | Current message judged valid |
| host_go_rt | input | 1 | Host command: return to Remote Terminal mode |
| host_wr | input | 1 | Host register write |
| host_rd | input | 1 | Host register read |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | WORD_W | Host write data |
| host_rdata | output | WORD_W | Host read data (combinational from host_addr) |
| mode_bc | output | 1 | 1 = Bus Controller, 0 = Remote Terminal |
| irq_o | output | 1 | OR of all interrupt flags |
| irq_vec_o | output | 4 | Individual interrupt flags |

## Verification
The assertions assume that the decoder strobes and msg_ok_stb are single-cycle pulses that are valid only while rst_n is high. They also assume that host_go_rt is not raised in the same cycle as a validated dynamic bus control command. The directed tests drive every strobe for exactly one clock on the falling edge and never overlap these two events, so the stimulus stays within those assumptions. Register reads use host_rd only on the cycle the value is sampled, so the read-clears-unread rule is exercised only where a test intends it.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
   localparam int unsigned N_IRQ   = 4;
   localparam int unsigned IRQ_RX  = 0;
   localparam int unsigned IRQ_TX  = 1;
   localparam int unsigned IRQ_MC  = 2;
   localparam int unsigned IRQ_OVR = 3;

   localparam int unsigned SA_LSB  = 5;
   localparam int unsigned SA_W    = 5;
   localparam int unsigned MC_LSB  = 0;
   localparam int unsigned MC_W    = 5;
   localparam int unsigned TX_BIT  = 10;

   typedef enum logic [2:0] {
      RA_CMD  = 3'd0,
      RA_SYNC = 3'd1,
      RA_VEC  = 3'd2,
      RA_IRQ  = 3'd3,
      RA_CTRL = 3'd4
   } reg_addr_e;
endpackage

// File: rtl/tcu_mode_ctl.sv
module tcu_mode_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic go_rt,
   input  logic dbc_hit,
   output logic mode_bc
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_bc <= 1'b0;
      else if (mode_bc && go_rt)
         mode_bc <= 1'b0;
      else if (!mode_bc && dbc_hit)
         mode_bc <= 1'b1;
   end
endmodule

// File: rtl/tcu_cmd_buf.sv
module tcu_cmd_buf #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_stb,
   input  logic [WORD_W-1:0] cmd_in,
   input  logic              ok_stb,
   input  logic              rd_stb,
   output logic [WORD_W-1:0] stage1,
   output logic [WORD_W-1:0] stage2,
   output logic              xfer,
   output logic              ovr_evt
);
   logic stage1_vld;
   logic unread;

   assign xfer    = ok_stb && stage1_vld;
   assign ovr_evt = xfer && unread && !rd_stb;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage1     <= '0;
         stage1_vld <= 1'b0;
      end else if (cmd_stb) begin
         stage1     <= cmd_in;
         stage1_vld <= 1'b1;
      end else if (xfer) begin
         stage1_vld <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage2 <= '0;
         unread <= 1'b0;
      end else if (xfer) begin
         stage2 <= stage1;
         unread <= 1'b1;
      end else if (rd_stb) begin
         unread <= 1'b0;
      end
   end
endmodule

// File: rtl/tcu_irq_bank.sv
module tcu_irq_bank #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] clr_vec,
   output logic [N-1:0] flags,
   output logic         irq
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)
            flags[i] <= 1'b0;
         else if (set_vec[i])
            flags[i] <= 1'b1;
         else if (clr_vec[i])
            flags[i] <= 1'b0;
      end
   end

   assign irq = |flags;
endmodule

// File: rtl/tcu_top.sv
module tcu_top
   import tcu_pkg::*;
#(
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned ADDR_W      = 3,
   parameter bit          ACCEPT_SA31 = 1'b1,
   parameter logic [4:0]  DBC_CODE    = 5'b00000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec_cmd_stb,
   input  logic              dec_sync_stb,
   input  logic [WORD_W-1:0] dec_word,
   input  logic              msg_ok_stb,
   input  logic              host_go_rt,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_rdata,
   output logic              mode_bc,
   output logic              irq_o,
   output logic [3:0]        irq_vec_o
);
   localparam logic [SA_W-1:0] SA_LO = '0;
   localparam logic [SA_W-1:0] SA_HI = '1;

   if (WORD_W < 16) begin : g_bad_w
      $error("tcu_top: WORD_W must be at least 16");
   end
   if (ADDR_W < 3) begin : g_bad_a
      $error("tcu_top: ADDR_W must be at least 3");
   end

   logic              rt_act;
   logic [WORD_W-1:0] stage1, cmd_hold;
   logic              xfer, ovr_evt;
   logic              rd_cmd;
   logic              is_mode, is_dbc;
   logic              dbc_en;
   logic [WORD_W-1:0] sync_q, vec_q;
   logic [N_IRQ-1:0]  irq_set, irq_clr, irq_flags;
   logic [SA_W-1:0]   sa_f;
   logic [MC_W-1:0]   mc_f;

   assign rt_act = !mode_bc;
   assign rd_cmd = host_rd && (host_addr == ADDR_W'(RA_CMD));
   assign sa_f   = stage1[SA_LSB +: SA_W];
   assign mc_f   = stage1[MC_LSB +: MC_W];

   if (ACCEPT_SA31) begin : g_sa_both
      assign is_mode = (sa_f == SA_LO) || (sa_f == SA_HI);
   end else begin : g_sa_zero
      assign is_mode = (sa_f == SA_LO);
   end
   assign is_dbc = is_mode && (mc_f == DBC_CODE);

   tcu_mode_ctl u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_rt   (host_go_rt),
      .dbc_hit (xfer && is_dbc && dbc_en),
      .mode_bc (mode_bc)
   );

   tcu_cmd_buf #(.WORD_W(WORD_W)) u_cbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_stb (dec_cmd_stb && rt_act),
      .cmd_in  (dec_word),
      .ok_stb  (msg_ok_stb && rt_act),
      .rd_stb  (rd_cmd),
      .stage1  (stage1),
      .stage2  (cmd_hold),
      .xfer    (xfer),
      .ovr_evt (ovr_evt)
   );

   always_comb begin
      irq_set          = '0;
      irq_set[IRQ_MC]  = xfer && is_mode;
      irq_set[IRQ_TX]  = xfer && !is_mode && stage1[TX_BIT];
      irq_set[IRQ_RX]  = xfer && !is_mode && !stage1[TX_BIT];
      irq_set[IRQ_OVR] = ovr_evt;
      irq_clr = (host_wr && host_addr == ADDR_W'(RA_IRQ)) ? host_wdata[N_IRQ-1:0] : '0;
   end

   tcu_irq_bank #(.N(N_IRQ)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (irq_set),
      .clr_vec (irq_clr),
      .flags   (irq_flags),
      .irq     (irq_o)
   );
   assign irq_vec_o = irq_flags;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         vec_q  <= '0;
         dbc_en <= 1'b0;
      end else begin
         if (dec_sync_stb && rt_act)
            sync_q <= dec_word;
         if (host_wr && host_addr == ADDR_W'(RA_VEC))
            vec_q <= host_wdata;
         if (host_wr && host_addr == ADDR_W'(RA_CTRL))
            dbc_en <= host_wdata[0];
      end
   end

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         ADDR_W'(RA_CMD):  host_rdata = cmd_hold;
         ADDR_W'(RA_SYNC): host_rdata = sync_q;
         ADDR_W'(RA_VEC):  host_rdata = vec_q;
         ADDR_W'(RA_IRQ):  host_rdata[N_IRQ-1:0] = irq_flags;
         ADDR_W'(RA_CTRL): host_rdata[1:0] = {mode_bc, dbc_en};
         default:          host_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tcu_chk.sv
module tcu_chk #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              msg_ok_stb,
   input logic              host_go_rt,
   input logic              host_wr,
   input logic [ADDR_W-1:0] host_addr,
   input logic              mode_bc,
   input logic              irq_o,
   input logic [3:0]        irq_flags,
   input logic [WORD_W-1:0] cmd_hold
);
   AST_RESET_RT: assert property (@(posedge clk) $rose(rst_n) |-> !mode_bc && !irq_o); // R1
   AST_BC_TO_RT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_bc && host_go_rt) |=> !mode_bc); // R2
   AST_DBC_NEEDS_OK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_bc) |-> $past(msg_ok_stb)); // R3
   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !msg_ok_stb |=> $stable(cmd_hold)); // R4
   AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flags[3]) |-> $past(msg_ok_stb)); // R5
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !(host_wr && host_addr == ADDR_W'(3))) |=> irq_o); // R9
   AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!msg_ok_stb && !irq_o) |=> !irq_o); // R8
endmodule

bind tcu_top tcu_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .msg_ok_stb (msg_ok_stb),
   .host_go_rt (host_go_rt),
   .host_wr    (host_wr),
   .host_addr  (host_addr),
   .mode_bc    (mode_bc),
   .irq_o      (irq_o),
   .irq_flags  (irq_flags),
   .cmd_hold   (cmd_hold)
);

// File: tb/sim_tcu_top.sv
`timescale 1ns/1ps
module sim_tcu_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dec_cmd_stb = 1'b0, dec_sync_stb = 1'b0, msg_ok_stb = 1'b0;
   logic [15:0] dec_word = '0;
   logic        host_go_rt = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
   logic [2:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        mode_bc, irq_o;
   logic [3:0]  irq_vec_o;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tcu_top u0 (
      .clk(clk), .rst_n(rst_n), .dec_cmd_stb(dec_cmd_stb), .dec_sync_stb(dec_sync_stb),
      .dec_word(dec_word), .msg_ok_stb(msg_ok_stb), .host_go_rt(host_go_rt),
      .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .mode_bc(mode_bc),
      .irq_o(irq_o), .irq_vec_o(irq_vec_o)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cmd(input logic [15:0] w);
      @(negedge clk); dec_cmd_stb = 1'b1; dec_word = w;
      @(negedge clk); dec_cmd_stb = 1'b0;
   endtask
   task automatic ok();
      @(negedge clk); msg_ok_stb = 1'b1;
      @(negedge clk); msg_ok_stb = 1'b0;
   endtask
   task automatic sync(input logic [15:0] w);
      @(negedge clk); dec_sync_stb = 1'b1; dec_word = w;
      @(negedge clk); dec_sync_stb = 1'b0;
   endtask
   task automatic go_rt();
      @(negedge clk); host_go_rt = 1'b1;
      @(negedge clk); host_go_rt = 1'b0;
   endtask
   task automatic hwr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk); host_wr = 1'b0;
   endtask
   task automatic hrd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk); host_addr = a; host_rd = 1'b1; #1 d = host_rdata;
      @(negedge clk); host_rd = 1'b0;
   endtask
   task automatic peek(input logic [2:0] a, output logic [15:0] d);
      host_addr = a; #1 d = host_rdata;
   endtask
   task automatic clear_all();
      logic [15:0] d;
      hrd(3'd0, d);
      hwr(3'd3, 16'h000F);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      chk("R1 mode", {15'd0, mode_bc}, 16'd0);
      chk("R1 irq", {15'd0, irq_o}, 16'd0);
      for (int a = 0; a < 5; a++) begin
         peek(3'(a), d);
         chk("R1 regs", d, 16'd0);
      end
   endtask

   task automatic t_two_stage();
      logic [15:0] d;
      cmd(16'h2864);
      peek(3'd0, d); chk("R4 stage1 hidden", d, 16'h0000);
      ok();
      hrd(3'd0, d); chk("R4 moved", d, 16'h2864);
      peek(3'd3, d); chk("R8 rx flag", d, 16'h0001);
      chk("R9 irq line", {15'd0, irq_o}, 16'd1);
      hwr(3'd3, 16'h0000);
      peek(3'd3, d); chk("R9 write0 no effect", d, 16'h0001);
      hwr(3'd3, 16'h0001);
      peek(3'd3, d); chk("R9 w1c", d, 16'h0000);
      chk("R9 irq low", {15'd0, irq_o}, 16'd0);
   endtask

   task automatic t_classes();
      logic [15:0] d;
      cmd(16'h2C64); ok();
      peek(3'd3, d); chk("R8 tx flag", d, 16'h0002);
      clear_all();
      cmd(16'h2C02); ok();
      peek(3'd3, d); chk("R8 mode flag", d, 16'h0004);
      chk("R3 no switch other code", {15'd0, mode_bc}, 16'd0);
      clear_all();
   endtask

   task automatic t_overrun();
      logic [15:0] d;
      cmd(16'h2861); ok();
      cmd(16'h2862); ok();
      peek(3'd3, d); chk("R5 overrun", d, 16'h0009);
      hrd(3'd0, d); chk("R5 newest kept", d, 16'h2862);
      hwr(3'd3, 16'h000F);
      cmd(16'h2863); ok(); hrd(3'd0, d);
      cmd(16'h2864); ok();
      peek(3'd3, d); chk("R5 no overrun after read", d, 16'h0001);
      clear_all();
   endtask

   task automatic t_stray();
      logic [15:0] d;
      ok();
      peek(3'd3, d); chk("R11 flags", d, 16'h0000);
      peek(3'd0, d); chk("R11 cmd", d, 16'h2864);
   endtask

   task automatic t_regs();
      logic [15:0] d;
      sync(16'h1234);
      peek(3'd1, d); chk("R6 sync", d, 16'h1234);
      hwr(3'd2, 16'hBEEF);
      peek(3'd2, d); chk("R7 vector", d, 16'hBEEF);
   endtask

   task automatic t_dbc();
      logic [15:0] d;
      cmd(16'h2FE0); ok();
      chk("R3 disabled", {15'd0, mode_bc}, 16'd0);
      clear_all();
      hwr(3'd4, 16'h0001);
      cmd(16'h2C00); ok();
      chk("R3 sa0 switch", {15'd0, mode_bc}, 16'd1);
      peek(3'd4, d); chk("R3 ctrl read", d, 16'h0003);
      clear_all();
   endtask

   task automatic t_bc_ignore();
      logic [15:0] d;
      cmd(16'h2864); ok(); sync(16'h5555);
      peek(3'd0, d); chk("R10 cmd", d, 16'h2C00);
      peek(3'd1, d); chk("R10 sync", d, 16'h1234);
      peek(3'd3, d); chk("R10 flags", d, 16'h0000);
   endtask

   task automatic t_go_rt();
      go_rt();
      chk("R2 bc to rt", {15'd0, mode_bc}, 16'd0);
      go_rt();
      chk("R2 rt stays", {15'd0, mode_bc}, 16'd0);
      cmd(16'h2FE0); ok();
      chk("R3 sa31 switch", {15'd0, mode_bc}, 16'd1);
      go_rt();
      chk("R2 back to rt", {15'd0, mode_bc}, 16'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_two_stage();
      t_classes();
      t_overrun();
      t_stray();
      t_regs();
      t_dbc();
      t_bc_ignore();
      t_go_rt();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule